// File: doc/BRIEF.md
# Time-of-Day Counter Controller

This block keeps a 64-bit time-of-day count that software brings up through a small register bus. A two-state control machine separates a halted phase, where a start value may be loaded and the count is frozen, from a counting phase, where every pulse on the primary step path adds one to the count. Software moves between the phases with self-clearing trigger writes and polls a status word until its running flag reads 1.

Two step paths feed independent checkers. With checking enabled, a step seen while halted, or a gap longer than a configurable window between steps while counting, latches an error for that path. Six message-received strobes latch informational flags. All error flags clear when ones are written to them, and a mask register keeps chosen flags off the interrupt line. The bus is a plain register interface: one write or one read per cycle, no back-pressure, writes take effect at the next clock edge, and read data is driven combinationally from the address.

Bit numbering in this brief is MSB-first: bit 0 of a 64-bit word is `bus_wdata[63]`, bit 63 is `bus_wdata[0]`.

Top module: `tod_timer_ctl`

## Requirements
- R1: After reset the state is Idle (status word 0), the count, control, mask and error registers read 0, and `irq` is low.
- R2: A write with bit 0 set to the halt trigger (address 1) puts the block in Not Set (status word 0x1) from any state; in Not Set the count does not change on step pulses.
- R3: A write to the load register (address 2) while not Running, whose bits 50 to 62 are all ones, sets the count to bits 0 to 31 of the written word in its upper half with the lower half zero; a load while Running leaves the count unchanged.
- R4: A load while not Running whose bits 50 to 62 are not all ones leaves the count unchanged and latches error bit 2.
- R5: A write with bit 0 set to the start trigger (address 3) moves Not Set to Running (status word 0x8000_0000_0000_0002, bit 0 being the running flag and bits 62:63 the state code 0 Idle, 1 Not Set, 2 Running); in Idle it is ignored.
- R6: In Running each clock with `step_in[0]` high adds one to the count (address 4).
- R7: With checking enabled (control register, address 0, bit 0), a step on path p while in Not Set latches error bit p (p = 0 or 1).
- R8: With checking enabled and the block Running, STEP_WINDOW consecutive cycles without a step on path p latch error bit p; steps spaced within the window latch nothing, and with checking disabled nothing is latched.
- R9: A pulse on `msg_rx[i]` latches error bit 38+i.
- R10: Writing ones to the error register (address 6) clears those bits; an event arriving in the same cycle as the clear keeps its bit set.
- R11: `irq` is high exactly when some error bit is set whose mask bit (address 7, same position) is 0.
- R12: The halt and start trigger addresses always read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr` |
| step_in | input | 2 | Step pulses, one per path; path 0 advances the count |
| msg_rx | input | 6 | Message-received event strobes |
| irq | output | 1 | Unmasked error present |

## Verification
A wrong state in the control machine shows at the status word on the first read after the trigger edge, and at the count within one step pulse, since a stuck or early Running state either fails to advance or advances while halted. A wrong window counter shows as an error flag one cycle too early or too late around the STEP_WINDOW boundary, so the bench samples both sides of that edge. Error-latch and mask faults surface on `irq` and the error word in the cycle after the event or write.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int WORD_W  = 64;
  localparam int ADDR_W  = 3;
  localparam int TIME_W  = 32;
  localparam int N_PATHS = 2;
  localparam int MSG_N   = 6;

  // MSB-first numbering inside the block
  typedef logic [0:WORD_W-1] word_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_NOTSET = 2'd1,
    ST_RUN    = 2'd2
  } tod_state_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_HALT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD   = 3'd2;
  localparam logic [ADDR_W-1:0] A_START  = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;
  localparam logic [ADDR_W-1:0] A_ERR    = 3'd6;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd7;

  localparam int FMT_LO     = 50;
  localparam int FMT_HI     = 62;
  localparam int ERR_STEP0  = 0;
  localparam int ERR_FMT    = 2;
  localparam int ERR_MSG_LO = 38;
endpackage

// File: rtl/tod_core.sv
module tod_core
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req,
  input  logic              start_req,
  input  logic              load_req,
  input  logic              load_fmt_ok,
  input  logic [0:TIME_W-1] load_time,
  input  logic              step,
  output tod_state_e        st_q,
  output word_t             cnt_q,
  output logic              fmt_err
);
  localparam int LOW_W = WORD_W - TIME_W;

  logic not_running;
  assign not_running = (st_q != ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (halt_req) begin
      st_q <= ST_NOTSET;
    end else if (start_req && st_q == ST_NOTSET) begin
      st_q <= ST_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_req && not_running && load_fmt_ok) begin
      cnt_q <= {load_time, {LOW_W{1'b0}}};
    end else if (!not_running && step) begin
      cnt_q <= word_t'(cnt_q + word_t'(1));
    end
  end

  assign fmt_err = load_req && not_running && !load_fmt_ok;
endmodule

// File: rtl/tod_step_chk.sv
module tod_step_chk #(
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic running,
  input  logic halted,
  input  logic step,
  output logic chk_err
);
  localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] gap_q;
  logic          expired;

  assign expired = en && running && !step && (gap_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (!en || !running || step || expired) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assign chk_err = expired || (en && halted && step);
endmodule

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  word_t             bus_wdata,
  input  tod_state_e        st,
  input  word_t             cnt,
  input  logic [N_PATHS-1:0] path_err,
  input  logic              fmt_err,
  input  logic [MSG_N-1:0]  msg_rx,
  output logic              halt_req,
  output logic              start_req,
  output logic              load_req,
  output logic              load_fmt_ok,
  output logic [0:TIME_W-1] load_time,
  output logic              chk_en,
  output word_t             err_q,
  output word_t             mask_q,
  output word_t             rdata,
  output logic              irq
);
  word_t err_set, err_clr, impl, status;

  assign halt_req    = bus_wr && bus_addr == A_HALT  && bus_wdata[0];
  assign start_req   = bus_wr && bus_addr == A_START && bus_wdata[0];
  assign load_req    = bus_wr && bus_addr == A_LOAD;
  assign load_fmt_ok = &bus_wdata[FMT_LO:FMT_HI];
  assign load_time   = bus_wdata[0:TIME_W-1];

  always_comb begin
    err_set = '0;
    impl    = '0;
    for (int p = 0; p < N_PATHS; p++) begin
      err_set[ERR_STEP0+p] = path_err[p];
      impl[ERR_STEP0+p]    = 1'b1;
    end
    err_set[ERR_FMT] = fmt_err;
    impl[ERR_FMT]    = 1'b1;
    for (int i = 0; i < MSG_N; i++) begin
      err_set[ERR_MSG_LO+i] = msg_rx[i];
      impl[ERR_MSG_LO+i]    = 1'b1;
    end
  end

  assign err_clr = (bus_wr && bus_addr == A_ERR) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= '0;
      mask_q <= '0;
      chk_en <= 1'b0;
    end else begin
      err_q <= (err_set | (err_q & ~err_clr)) & impl;
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata;
      if (bus_wr && bus_addr == A_CTRL) chk_en <= bus_wdata[0];
    end
  end

  always_comb begin
    status        = '0;
    status[0]     = (st == ST_RUN);
    status[62:63] = st;
  end

  always_comb begin
    rdata = '0;
    unique case (bus_addr)
      A_CTRL:   rdata[0] = chk_en;
      A_COUNT:  rdata = cnt;
      A_STATUS: rdata = status;
      A_ERR:    rdata = err_q;
      A_MASK:   rdata = mask_q;
      default:  rdata = '0;
    endcase
  end

  assign irq = |(err_q & ~mask_q);
endmodule

// File: rtl/tod_timer_ctl.sv
module tod_timer_ctl
  import tod_pkg::*;
#(
  parameter int STEP_WINDOW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic [N_PATHS-1:0] step_in,
  input  logic [MSG_N-1:0]   msg_rx,
  output logic               irq
);
  word_t             wdata_w, rdata_w, cnt_w, err_w, mask_w;
  tod_state_e        st_w;
  logic              halt_w, start_w, load_w, fmt_ok_w, fmt_err_w, chk_en_w;
  logic [0:TIME_W-1] ltime_w;
  logic [N_PATHS-1:0] path_err_w;

  assign wdata_w   = bus_wdata;
  assign bus_rdata = rdata_w;

  tod_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(wdata_w), .st(st_w), .cnt(cnt_w), .path_err(path_err_w),
    .fmt_err(fmt_err_w), .msg_rx(msg_rx), .halt_req(halt_w),
    .start_req(start_w), .load_req(load_w), .load_fmt_ok(fmt_ok_w),
    .load_time(ltime_w), .chk_en(chk_en_w), .err_q(err_w),
    .mask_q(mask_w), .rdata(rdata_w), .irq(irq)
  );

  tod_core u_core (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_w), .start_req(start_w),
    .load_req(load_w), .load_fmt_ok(fmt_ok_w), .load_time(ltime_w),
    .step(step_in[0]), .st_q(st_w), .cnt_q(cnt_w), .fmt_err(fmt_err_w)
  );

  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    tod_step_chk #(.WINDOW(STEP_WINDOW)) u_chk (
      .clk(clk), .rst_n(rst_n), .en(chk_en_w),
      .running(st_w == ST_RUN), .halted(st_w == ST_NOTSET),
      .step(step_in[p]), .chk_err(path_err_w[p])
    );
  end
endmodule

// File: rtl/tod_timer_ctl_chk.sv
module tod_timer_ctl_chk
  import tod_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [WORD_W-1:0]  bus_wdata,
  input logic [N_PATHS-1:0] step_in,
  input logic [MSG_N-1:0]   msg_rx,
  input logic               irq,
  input tod_state_e         st,
  input word_t              cnt,
  input word_t              err,
  input word_t              mask
);
  AST_HALT_NOTSET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_HALT && bus_wdata[63]) |=> st == ST_NOTSET); // R2
  AST_NOTSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NOTSET && !bus_wr) |=> $stable(cnt)); // R2
  AST_RUN_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && bus_wr && bus_addr == A_LOAD && !step_in[0]) |=> $stable(cnt)); // R3
  AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NOTSET && bus_wr && bus_addr == A_START && bus_wdata[63]) |=> st == ST_RUN); // R5
  AST_STEP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && step_in[0] && !bus_wr) |=> cnt == word_t'($past(cnt) + word_t'(1))); // R6
  AST_MSG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    msg_rx[0] |=> err[ERR_MSG_LO]); // R9
  AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq); // R11
endmodule

bind tod_timer_ctl tod_timer_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .step_in(step_in), .msg_rx(msg_rx), .irq(irq),
  .st(st_w), .cnt(cnt_w), .err(err_w), .mask(mask_w)
);

// File: tb/tod_timer_ctl_tb.sv
module tod_timer_ctl_tb;
  localparam int WIN = 16;
  localparam logic [63:0] B0 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] LD1 = 64'h1234_5678_0000_3FFE;
  localparam logic [63:0] C1  = 64'h1234_5678_0000_0000;
  // op: 0 write, 1 read-check, 2 step both paths
  localparam int NV = 22;
  localparam logic [72:0] TBL [NV] = '{
    {2'd1, 3'd5, 64'h0, 4'd1},                     // R1 status idle
    {2'd1, 3'd4, 64'h0, 4'd1},                     // R1 count zero
    {2'd0, 3'd1, B0, 4'd2},                        // halt
    {2'd1, 3'd5, 64'h1, 4'd2},                     // R2 not set
    {2'd1, 3'd1, 64'h0, 4'd12},                    // R12 halt reads 0
    {2'd0, 3'd2, LD1, 4'd3},                       // load
    {2'd1, 3'd4, C1, 4'd3},                        // R3 loaded
    {2'd2, 3'd0, 64'h0, 4'd2},                     // step while halted
    {2'd1, 3'd4, C1, 4'd2},                        // R2 frozen
    {2'd0, 3'd3, B0, 4'd5},                        // start
    {2'd1, 3'd5, 64'h8000_0000_0000_0002, 4'd5},   // R5 running
    {2'd1, 3'd3, 64'h0, 4'd12},                    // R12 start reads 0
    {2'd2, 3'd0, 64'h0, 4'd6},
    {2'd2, 3'd0, 64'h0, 4'd6},
    {2'd1, 3'd4, C1 + 64'd2, 4'd6},                // R6 two steps
    {2'd0, 3'd2, 64'hAAAA_0000_0000_3FFE, 4'd3},   // load while running
    {2'd1, 3'd4, C1 + 64'd2, 4'd3},                // R3 ignored
    {2'd0, 3'd1, B0, 4'd2},
    {2'd1, 3'd5, 64'h1, 4'd2},                     // R2 from running
    {2'd2, 3'd0, 64'h0, 4'd2},
    {2'd1, 3'd4, C1 + 64'd2, 4'd2},                // R2 frozen again
    {2'd1, 3'd6, 64'h0, 4'd8}                      // R8 no error, check off
  };

  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [2:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0, bus_rdata;
  logic [1:0]  step_in = '0;
  logic [5:0]  msg_rx = '0, dummy;
  logic        irq;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  tod_timer_ctl #(.STEP_WINDOW(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .step_in(step_in),
    .msg_rx(msg_rx), .irq(irq)
  );

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [63:0] exp, input int req);
    @(negedge clk); bus_addr = a; #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL R%0d addr %0d actual %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input int req);
    @(negedge clk); #1;
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL R%0d irq actual %b expected %b", req, irq, exp);
    end
  endtask

  task automatic step(input logic [1:0] s);
    @(negedge clk); step_in = s;
    @(negedge clk); step_in = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    dummy = '0;
    do_reset();
    chk_irq(1'b0, 1);                     // R1
    rd(3'd7, 64'h0, 1);                   // R1 mask
    rd(3'd0, 64'h0, 1);                   // R1 ctrl
    for (int i = 0; i < NV; i++) begin
      case (TBL[i][72:71])
        2'd0: wr(TBL[i][70:68], TBL[i][67:4]);
        2'd1: rd(TBL[i][70:68], TBL[i][67:4], int'(TBL[i][3:0]));
        default: step(2'b11);
      endcase
    end

    // R5: start ignored in idle
    do_reset();
    wr(3'd3, B0);
    rd(3'd5, 64'h0, 5);

    // R4: malformed load (bit 50 clear)
    wr(3'd2, 64'h1234_5678_0000_1FFE);
    rd(3'd4, 64'h0, 4);
    rd(3'd6, 64'h2000_0000_0000_0000, 4);
    // R10: write ones clears
    wr(3'd6, '1);
    rd(3'd6, 64'h0, 10);

    // R7: step on path 1 while halted, checking on
    wr(3'd0, B0);
    rd(3'd0, B0, 7);
    wr(3'd1, B0);
    step(2'b10);
    rd(3'd6, 64'h4000_0000_0000_0000, 7);
    wr(3'd6, '1);

    // R8: steps inside the window keep errors clear
    wr(3'd2, LD1);
    wr(3'd3, B0);
    for (int k = 0; k < 10; k++) begin
      step(2'b11);
      @(negedge clk); @(negedge clk);
    end
    rd(3'd6, 64'h0, 8);
    // R8: window boundary after a fresh start
    wr(3'd1, B0);
    wr(3'd3, B0);
    repeat (WIN - 3) @(negedge clk);
    rd(3'd6, 64'h0, 8);               // after edge WIN-2
    repeat (2) @(negedge clk);
    rd(3'd6, 64'hC000_0000_0000_0000, 8);
    wr(3'd0, 64'h0);
    wr(3'd6, '1);
    rd(3'd6, 64'h0, 10);

    // R9 / R11: message flag and mask
    @(negedge clk); msg_rx = 6'b000001;
    @(negedge clk); msg_rx = '0;
    rd(3'd6, 64'h0000_0000_0200_0000, 9);
    chk_irq(1'b1, 11);
    wr(3'd7, 64'h0000_0000_03F0_0000);
    chk_irq(1'b0, 11);
    @(negedge clk); msg_rx = 6'b100000;
    @(negedge clk); msg_rx = '0;
    rd(3'd6, 64'h0000_0000_0210_0000, 9);
    chk_irq(1'b0, 11);
    wr(3'd7, 64'h0);
    chk_irq(1'b1, 11);

    // R10: set in same cycle as clear wins
    @(negedge clk); bus_wr = 1; bus_addr = 3'd6; bus_wdata = '1; msg_rx = 6'b000010;
    @(negedge clk); bus_wr = 0; bus_wdata = '0; msg_rx = '0;
    rd(3'd6, 64'h0000_0000_0100_0000, 10);
    wr(3'd6, '1);
    chk_irq(1'b0, 11);

    finish_run();
  end
endmodule